// File: doc/BRIEF.md
# Oscillator-Free BPSK Data and Clock Recovery

This block takes a binary phase-shift keyed carrier that an analog front end has already squared up to a logic level, together with a strobe that fires twice per carrier period. It returns the transmitted bit and a regenerated bit clock. It has no local oscillator, no phase-locked loop, no edge timer and no filter. Each strobe captures the carrier level. A one-strobe delay of that capture gives a sample that is half a carrier period old. A phase reversal shows up as two equal neighbouring samples. The live sample and the half-cycle-old sample form a pair. When the two agree, the pair sets the data bit. When they differ, the bit keeps its value. The recovered clock is the live sample XORed with the data bit. The data can change once per carrier period, so the data rate can equal the carrier frequency.

The block runs from a single system clock. Each external input passes through a parameterised synchronizer. The strobe is taken either as a one-cycle pulse or as a level whose rising edge counts, chosen at elaboration. A one-cycle diagnostic flag marks three equal samples in a row, which a valid carrier never produces. The detector keeps applying its rule when the flag fires.

Top module: `bpsk_hold_demod`

## Requirements
- R1: While rst_n is low and in the cycle after, data_out, rclk_out and illegal_out are 0.
- R2: The outputs change only in response to a strobe: changing carrier_in while no strobe arrives leaves data_out and rclk_out unchanged.
- R3: The first strobe after reset only fills the delay stage and does not change any output.
- R4: When the live sample and the half-cycle-old sample are both 0, data_out becomes 0.
- R5: When the live sample and the half-cycle-old sample are both 1, data_out becomes 1.
- R6: When the live sample and the half-cycle-old sample differ, data_out keeps its previous value.
- R7: rclk_out takes the XOR of the live sample and the data_out value it is updated with.
- R8: illegal_out is high for exactly one cycle when the three most recent strobed samples are equal, and the data rule is still applied on that strobe.
- R9: With the default pulse-mode strobe, an input sample driven alongside a strobe pulse that is sampled at clock edge k appears on the outputs after edge k+SYNC_STAGES+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| carrier_in | input | 1 | Digitized carrier level, asynchronous to clk |
| strobe_in | input | 1 | Strobe at twice the carrier rate (a pulse or a level, by parameter) |
| data_out | output | 1 | Recovered data bit |
| rclk_out | output | 1 | Recovered bit clock |
| illegal_out | output | 1 | One-cycle flag for three equal samples in a row |

## Verification
The bench feeds the block every 8-sample carrier sequence. Each one covers every mix of phase reversals, steady phase and stuck carrier. A detector with a swapped or missing hold rule would give the wrong bit on the strobe after a reversal. A clock formed from the old data would produce a glitch. At each strobe the outputs are sampled one cycle before and one cycle after the expected update. A wrong synchronizer depth or a missing pipeline stage would show up as an early or late change. Between sequences the carrier toggles with no strobe, to catch a sampler that tracks the carrier freely. The first strobe after reset is also checked, since the delay stage holds no real sample then and a design that decoded the reset value would report false data.

// File: rtl/bpsk_demod_pkg.sv
package bpsk_demod_pkg;

   // Live sample and the sample one strobe (half a carrier period) older.
   typedef struct packed {
      logic live;
      logic late;
   } sample_pair_t;

   // A pair of equal samples marks a phase reversal and forces the data bit.
   function automatic logic pair_forces(sample_pair_t p);
      return p.live ~^ p.late;
   endfunction

   localparam int unsigned WARMUP_STROBES = 2;

endpackage

// File: rtl/bpsk_sync.sv
module bpsk_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("bpsk_sync: STAGES must be at least 1");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= '0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/bpsk_pair_sampler.sv
module bpsk_pair_sampler
   import bpsk_demod_pkg::*;
#(
   parameter bit STROBE_EDGE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         carrier_s,
   input  logic         strobe_s,
   output sample_pair_t pair,
   output logic         upd
);

   localparam int unsigned CNT_W = $clog2(WARMUP_STROBES + 1);

   logic             en;
   logic [CNT_W-1:0] seen;

   generate
      if (STROBE_EDGE) begin : g_edge
         logic strobe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobe_q <= 1'b0;
            else        strobe_q <= strobe_s;
         end
         assign en = strobe_s & ~strobe_q;
      end else begin : g_pulse
         assign en = strobe_s;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pair <= '0;
         seen <= '0;
         upd  <= 1'b0;
      end else begin
         upd <= en && (seen >= CNT_W'(WARMUP_STROBES - 1));
         if (en) begin
            pair.live <= carrier_s;
            pair.late <= pair.live;
            if (seen != CNT_W'(WARMUP_STROBES)) seen <= seen + 1'b1;
         end
      end
   end

endmodule

// File: rtl/bpsk_hold_detect.sv
module bpsk_hold_detect
   import bpsk_demod_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  sample_pair_t pair,
   input  logic         upd,
   output logic         data_q,
   output logic         rclk_q,
   output logic         illegal_q
);

   sample_pair_t prev;
   logic         prev_ok;
   logic         next_data;

   assign next_data = pair_forces(pair) ? pair.live : data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= 1'b0;
         rclk_q    <= 1'b0;
         illegal_q <= 1'b0;
         prev      <= '0;
         prev_ok   <= 1'b0;
      end else begin
         illegal_q <= 1'b0;
         if (upd) begin
            data_q    <= next_data;
            rclk_q    <= pair.live ^ next_data;
            prev      <= pair;
            prev_ok   <= 1'b1;
            illegal_q <= prev_ok && pair_forces(prev) && pair_forces(pair)
                         && (prev.live == pair.live);
         end
      end
   end

endmodule

// File: rtl/bpsk_hold_demod.sv
module bpsk_hold_demod
   import bpsk_demod_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          STROBE_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic carrier_in,
   input  logic strobe_in,
   output logic data_out,
   output logic rclk_out,
   output logic illegal_out
);

   localparam int unsigned IN_W = 2;

   logic [IN_W-1:0] raw_in;
   logic [IN_W-1:0] synced;
   sample_pair_t    pair;
   logic            upd;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("bpsk_hold_demod: SYNC_STAGES must be at least 1");
      end
   endgenerate

   assign raw_in = {strobe_in, carrier_in};

   bpsk_sync #(.STAGES(SYNC_STAGES), .WIDTH(IN_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (synced)
   );

   bpsk_pair_sampler #(.STROBE_EDGE(STROBE_EDGE)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .carrier_s (synced[0]),
      .strobe_s  (synced[1]),
      .pair      (pair),
      .upd       (upd)
   );

   bpsk_hold_detect u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .pair      (pair),
      .upd       (upd),
      .data_q    (data_out),
      .rclk_q    (rclk_out),
      .illegal_q (illegal_out)
   );

endmodule

// File: rtl/bpsk_hold_demod_chk.sv
module bpsk_hold_demod_chk (
   input logic clk,
   input logic rst_n,
   input logic upd,
   input logic pair_live,
   input logic pair_late,
   input logic data_out,
   input logic rclk_out,
   input logic illegal_out
);

   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (!data_out && !rclk_out && !illegal_out));

   assert_quiet_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(upd) |-> ($stable(data_out) && $stable(rclk_out)));

   assert_zero_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !pair_live && !pair_late) |=> !data_out);

   assert_one_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && pair_live && pair_late) |=> data_out);

   assert_mixed_pair_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && (pair_live != pair_late)) |=> $stable(data_out));

   assert_clock_is_xor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> ((rclk_out ^ data_out) == $past(pair_live)));

   assert_flag_follows_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_out |-> $past(upd));

endmodule

bind bpsk_hold_demod bpsk_hold_demod_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .upd         (upd),
   .pair_live   (pair.live),
   .pair_late   (pair.late),
   .data_out    (data_out),
   .rclk_out    (rclk_out),
   .illegal_out (illegal_out)
);

// File: tb/tb_bpsk_hold_demod.sv
`timescale 1ns/1ps
module tb_bpsk_hold_demod;

   localparam int unsigned N      = 2;
   localparam int unsigned SEQ_LEN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic carrier_in = 1'b0;
   logic strobe_in = 1'b0;
   logic data_out, rclk_out, illegal_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bpsk_hold_demod #(.SYNC_STAGES(N), .STROBE_EDGE(1'b0)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .carrier_in  (carrier_in),
      .strobe_in   (strobe_in),
      .data_out    (data_out),
      .rclk_out    (rclk_out),
      .illegal_out (illegal_out)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; carrier_in = 1'b0; strobe_in = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 data", data_out, 1'b0);
      check("R1 rclk", rclk_out, 1'b0);
      check("R1 flag", illegal_out, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 data after release", data_out, 1'b0);
      check("R1 rclk after release", rclk_out, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int seq = 0; seq < (1 << SEQ_LEN); seq++) begin
         logic exp_d, exp_c, exp_f, old_d, old_c;
         logic [SEQ_LEN-1:0] s;
         s = SEQ_LEN'(seq);
         do_reset();
         exp_d = 1'b0; exp_c = 1'b0;
         for (int i = 0; i < SEQ_LEN; i++) begin
            old_d = exp_d; old_c = exp_c; exp_f = 1'b0;
            if (i >= 1) begin
               if (s[i] == s[i-1]) exp_d = s[i];
               exp_c = s[i] ^ exp_d;
               if (i >= 2) exp_f = (s[i] == s[i-1]) && (s[i-1] == s[i-2]);
            end
            // drive sample with a one-cycle strobe, sampled at the next edge k
            @(negedge clk);
            carrier_in = s[i]; strobe_in = 1'b1;
            @(negedge clk);
            strobe_in = 1'b0;
            repeat (N) @(negedge clk);
            // after edge k+N: nothing has moved yet
            check("R9 data not early", data_out, old_d);
            check("R9 rclk not early", rclk_out, old_c);
            check("R9 flag not early", illegal_out, 1'b0);
            @(negedge clk);
            // after edge k+N+1: new values
            if (i == 0) begin
               check("R3 data", data_out, 1'b0);
               check("R3 rclk", rclk_out, 1'b0);
            end else if (s[i] != s[i-1]) begin
               check("R6 hold", data_out, exp_d);
            end else if (s[i]) begin
               check("R5 one pair", data_out, exp_d);
            end else begin
               check("R4 zero pair", data_out, exp_d);
            end
            check("R7 rclk", rclk_out, exp_c);
            check("R8 flag", illegal_out, exp_f);
            @(negedge clk);
            check("R8 flag one cycle", illegal_out, 1'b0);
         end
         // toggle the carrier with no strobe: outputs must not move
         for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            carrier_in = ~carrier_in;
         end
         repeat (N + 3) @(negedge clk);
         check("R2 data stable", data_out, exp_d);
         check("R2 rclk stable", rclk_out, exp_c);
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule